// File: doc/BRIEF.md
# Link Receive Character Status and Acquisition Machine

This block sits behind the comma aligner and the 8b/10b decoder on the receive side of a serial link that carries 16-bit words. Each clock it takes one decoded character pair, a K (control) flag for each byte and a single code-violation flag. From these it sorts the word into one of five classes: idle, carrier extend, error propagation, normal data or invalid. It then drives two status lines, data-valid and error, together with the registered word.

A small acquisition machine decides when the receiver reports valid data. After reset it hunts for idles. It moves to the synchronized state after a run of consecutive idles, after a single carrier extend, or at once on data or an error-propagation code. Until then data-valid is held low. Once synchronized, the machine stays there until the next reset. A corrupt word is still reported, but it does not drop the link.

All outputs are registered. The word presented before a rising edge is reflected on the outputs right after that edge, and `in_sync_o` shows the state that the word left the machine in.

Top module: `rx_char_status`

## Requirements
- R1: In the synchronized state a normal data word (both K flags 0, no code violation) gives rx_dv_o=1, rx_er_o=0 and rx_word_o equal to the input word, one clock after it is presented.
- R2: An idle pair is upper byte [15:8]=0xBC with its K flag (rx_kflag_i[1]) set, and lower byte [7:0]=0xC5 or 0x50 with rx_kflag_i[0] clear. It gives rx_dv_o=0 and rx_er_o=0, and the pair appears on rx_word_o.
- R3: Carrier extend (0xF7F7 with both K flags set) gives rx_dv_o=0, rx_er_o=1 and rx_word_o=0xF7F7, in either state.
- R4: In the synchronized state, error propagation (0xFEFE with both K flags set) gives rx_dv_o=1, rx_er_o=1 and rx_word_o=0xFEFE.
- R5: In the synchronized state a word is invalid when rx_cv_i=1 (which takes priority over every pattern) or when it matches none of R1 to R4 (for example any other K combination). An invalid word gives rx_dv_o=1 and rx_er_o=1, and rx_word_o is unspecified.
- R6: While reset is asserted, and on release, in_sync_o=0, rx_dv_o=0, rx_er_o=0 and rx_word_o=0.
- R7: In acquisition, the third consecutive idle raises in_sync_o on the same edge that registers that idle. Two idles alone leave it low.
- R8: In acquisition, one carrier extend moves the machine to the synchronized state.
- R9: In acquisition, a normal data word or an error-propagation word moves the machine at once to the synchronized state.
- R10: A word received while in acquisition is reported with rx_dv_o=0 whatever its class. rx_er_o still follows the class (1 for carrier extend, error propagation and invalid).
- R11: In acquisition, an invalid word resets the consecutive-idle count, so that idle, idle, invalid, idle, idle leaves in_sync_o low.
- R12: Once synchronized, the machine stays synchronized for every input, code violations included, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word_i | input | DATA_W | Decoded character pair; [15:8] is the first character |
| rx_kflag_i | input | DATA_W/8 | K flag for each byte; bit 1 belongs to [15:8] |
| rx_cv_i | input | 1 | Decoder reported a code violation in this word |
| rx_dv_o | output | 1 | Data-valid status |
| rx_er_o | output | 1 | Error / carrier-extend status |
| rx_word_o | output | DATA_W | Registered word |
| in_sync_o | output | 1 | Machine is in the synchronized state |

## Verification
The status encoding is swept over every K-flag combination, both code-violation levels and all 64 pairings of eight byte values. These byte values include each control and filler character, so near-miss patterns get tried: a comma byte with the wrong filler, a filler marked as K, half of a carrier extend. The same sweep runs once from acquisition, where every single word must show data-valid low and must move the machine only for the entry classes. It runs again in the synchronized state, where it separates all five classes and shows the state never drops. Pseudo-random runs of idles mixed with other classes, with a reset every sixteen words, probe the idle-run counter and the rule that an interruption clears it.

// File: rtl/rx_char_pkg.sv
package rx_char_pkg;

    // Classes a received character pair can fall into
    typedef enum logic [2:0] {
        CLS_IDLE    = 3'd0,
        CLS_CAREXT  = 3'd1,
        CLS_DATA    = 3'd2,
        CLS_ERRPROP = 3'd3,
        CLS_INVALID = 3'd4
    } char_class_e;

    typedef enum logic {
        ST_ACQ  = 1'b0,
        ST_SYNC = 1'b1
    } link_state_e;

    // 8b/10b character values seen on the decoded byte lanes
    localparam logic [7:0] CH_K28_5 = 8'hBC;
    localparam logic [7:0] CH_D5_6  = 8'hC5;
    localparam logic [7:0] CH_D16_2 = 8'h50;
    localparam logic [7:0] CH_K23_7 = 8'hF7;
    localparam logic [7:0] CH_K30_7 = 8'hFE;

endpackage

// File: rtl/rx_char_classify.sv
module rx_char_classify
    import rx_char_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]   word_i,
    input  logic [DATA_W/8-1:0] kflag_i,
    input  logic                cv_i,
    output char_class_e         cls_o
);

    localparam int NB = DATA_W / 8;

    logic [NB-1:0] lane_k237;
    logic [NB-1:0] lane_k307;
    logic [NB-1:0] lane_filler;

    // Per-lane character matches
    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [7:0] ch;
        assign ch             = word_i[8*b +: 8];
        assign lane_k237[b]   = kflag_i[b] && (ch == CH_K23_7);
        assign lane_k307[b]   = kflag_i[b] && (ch == CH_K30_7);
        assign lane_filler[b] = !kflag_i[b] && ((ch == CH_D5_6) || (ch == CH_D16_2));
    end

    logic comma_top;
    logic fill_rest;
    logic idle_match;

    assign comma_top = kflag_i[NB-1] && (word_i[DATA_W-1 -: 8] == CH_K28_5);

    if (NB > 1) begin : g_rest
        assign fill_rest = &lane_filler[NB-2:0];
    end else begin : g_single
        assign fill_rest = 1'b1;
    end

    assign idle_match = comma_top && fill_rest;

    always_comb begin
        if (cv_i) begin
            cls_o = CLS_INVALID;
        end else if (kflag_i == '0) begin
            cls_o = CLS_DATA;
        end else if (&lane_k237) begin
            cls_o = CLS_CAREXT;
        end else if (&lane_k307) begin
            cls_o = CLS_ERRPROP;
        end else if (idle_match) begin
            cls_o = CLS_IDLE;
        end else begin
            cls_o = CLS_INVALID;
        end
    end

endmodule

// File: rtl/rx_acq_fsm.sv
module rx_acq_fsm
    import rx_char_pkg::*;
#(
    parameter int IDLE_RUN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  char_class_e cls_i,
    output link_state_e state_q_o
);

    localparam int             CW   = $clog2(IDLE_RUN + 1);
    localparam logic [CW-1:0]  LAST = CW'(IDLE_RUN - 1);

    typedef struct packed {
        link_state_e   st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.st == ST_ACQ) begin
            unique case (cls_i)
                CLS_IDLE: begin
                    if (r_q.cnt == LAST) begin
                        r_d.st  = ST_SYNC;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                CLS_CAREXT, CLS_DATA, CLS_ERRPROP: begin
                    r_d.st  = ST_SYNC;
                    r_d.cnt = '0;
                end
                default: r_d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_ACQ;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q_o = r_q.st;

    // R12: synchronized state is held until reset
    assert_sync_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SYNC) |=> (r_q.st == ST_SYNC));

    // R8 / R9: single entry words
    assert_carext_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACQ && cls_i == CLS_CAREXT) |=> (r_q.st == ST_SYNC));

    assert_fast_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACQ && (cls_i == CLS_DATA || cls_i == CLS_ERRPROP)) |=> (r_q.st == ST_SYNC));

    // R11: invalid word in acquisition clears the idle run
    assert_invalid_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACQ && cls_i == CLS_INVALID) |=> (r_q.st == ST_ACQ && r_q.cnt == '0));

    // R7: idle run counter never reaches the run length
    assert_idle_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(IDLE_RUN));

endmodule

// File: rtl/rx_status_out.sv
module rx_status_out
    import rx_char_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  char_class_e       cls_i,
    input  link_state_e       state_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              dv_o,
    output logic              er_o,
    output logic [DATA_W-1:0] word_o
);

    typedef struct packed {
        logic              dv;
        logic              er;
        logic [DATA_W-1:0] word;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        o_d.word = word_i;
        unique case (cls_i)
            CLS_IDLE:    begin o_d.dv = 1'b0; o_d.er = 1'b0; end
            CLS_CAREXT:  begin o_d.dv = 1'b0; o_d.er = 1'b1; end
            CLS_DATA:    begin o_d.dv = 1'b1; o_d.er = 1'b0; end
            default:     begin o_d.dv = 1'b1; o_d.er = 1'b1; end
        endcase
        // data-valid is withheld until the link is synchronized
        if (state_i == ST_ACQ) begin
            o_d.dv = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign dv_o   = o_q.dv;
    assign er_o   = o_q.er;
    assign word_o = o_q.word;

    assert_data_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SYNC && cls_i == CLS_DATA) |=> (dv_o && !er_o && word_o == $past(word_i)));

    assert_carext_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == CLS_CAREXT) |=> (!dv_o && er_o));

    assert_errprop_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == CLS_ERRPROP) |=> (er_o && word_o == $past(word_i)));

    assert_acq_no_dv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_ACQ) |=> !dv_o);

endmodule

// File: rtl/rx_char_status.sv
module rx_char_status
    import rx_char_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int IDLE_RUN = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   rx_word_i,
    input  logic [DATA_W/8-1:0] rx_kflag_i,
    input  logic                rx_cv_i,
    output logic                rx_dv_o,
    output logic                rx_er_o,
    output logic [DATA_W-1:0]   rx_word_o,
    output logic                in_sync_o
);

    char_class_e cls;
    link_state_e state_q;

    rx_char_classify #(.DATA_W(DATA_W)) u_classify (
        .word_i  (rx_word_i),
        .kflag_i (rx_kflag_i),
        .cv_i    (rx_cv_i),
        .cls_o   (cls)
    );

    rx_acq_fsm #(.IDLE_RUN(IDLE_RUN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls_i     (cls),
        .state_q_o (state_q)
    );

    rx_status_out #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cls_i   (cls),
        .state_i (state_q),
        .word_i  (rx_word_i),
        .dv_o    (rx_dv_o),
        .er_o    (rx_er_o),
        .word_o  (rx_word_o)
    );

    assign in_sync_o = (state_q == ST_SYNC);

    // R6: while reset is held the status outputs are quiet (checked in the cycle after)
    assert_reset_quiet_R6: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rx_dv_o && !rx_er_o && !in_sync_o));

endmodule

// File: tb/sim_rx_char_status.sv
module sim_rx_char_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] word_i = '0;
    logic [1:0]  kflag_i = '0;
    logic        cv_i = 1'b0;
    logic        dv_o, er_o, sync_o;
    logic [15:0] word_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit m_sync = 0;
    int m_cnt  = 0;

    always #10 clk = ~clk;

    rx_char_status #(.DATA_W(16), .IDLE_RUN(3)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_word_i  (word_i),
        .rx_kflag_i (kflag_i),
        .rx_cv_i    (cv_i),
        .rx_dv_o    (dv_o),
        .rx_er_o    (er_o),
        .rx_word_o  (word_o),
        .in_sync_o  (sync_o)
    );

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // class codes: 0 idle, 1 carrier extend, 2 data, 3 error propagation, 4 invalid
    function automatic int classify(input logic [15:0] d, input logic [1:0] k, input logic cv);
        if (cv) return 4;
        if (k == 2'b00) return 2;
        if (k == 2'b11 && d == 16'hF7F7) return 1;
        if (k == 2'b11 && d == 16'hFEFE) return 3;
        if (k == 2'b10 && d[15:8] == 8'hBC && (d[7:0] == 8'hC5 || d[7:0] == 8'h50)) return 0;
        return 4;
    endfunction

    function automatic string cls_req(input int c);
        case (c)
            0: return "R2";
            1: return "R3";
            2: return "R1";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        word_i = '0; kflag_i = '0; cv_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6", "dv in reset", dv_o, 0);
        check("R6", "er in reset", er_o, 0);
        check("R6", "sync in reset", sync_o, 0);
        check("R6", "word in reset", word_o, 0);
        rst_n = 1'b1;
        m_sync = 0;
        m_cnt  = 0;
    endtask

    // drive one word at a falling edge, check it after the next rising edge
    task automatic apply(input logic [15:0] d, input logic [1:0] k, input logic cv);
        int  c;
        bit  was_sync;
        bit  exp_dv, exp_er;
        string sreq;
        c        = classify(d, k, cv);
        was_sync = m_sync;
        exp_er   = (c == 1 || c == 3 || c == 4);
        exp_dv   = was_sync && (c == 2 || c == 3 || c == 4);
        if (!was_sync) begin
            case (c)
                0: begin
                    if (m_cnt == 2) begin m_sync = 1; m_cnt = 0; end
                    else m_cnt++;
                    sreq = "R7";
                end
                1: begin m_sync = 1; m_cnt = 0; sreq = "R8"; end
                2, 3: begin m_sync = 1; m_cnt = 0; sreq = "R9"; end
                default: begin m_cnt = 0; sreq = "R11"; end
            endcase
        end else begin
            sreq = "R12";
        end
        word_i = d; kflag_i = k; cv_i = cv;
        @(posedge clk);
        @(negedge clk);
        check(was_sync ? cls_req(c) : "R10", "dv", dv_o, exp_dv);
        check(cls_req(c), "er", er_o, exp_er);
        if (c != 4) check(cls_req(c), "word", word_o, d);
        check(sreq, "in_sync", sync_o, m_sync);
    endtask

    function automatic logic [7:0] pick(input int i);
        case (i)
            0: return 8'hBC;
            1: return 8'hC5;
            2: return 8'h50;
            3: return 8'hF7;
            4: return 8'hFE;
            5: return 8'h00;
            6: return 8'hA5;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [18:0] rand_word(input logic [15:0] r);
        // returns {cv, k[1:0], data}
        case (r[2:0])
            3'd0, 3'd1: return {1'b0, 2'b10, 16'hBCC5};
            3'd2:       return {1'b0, 2'b10, 16'hBC50};
            3'd3:       return {1'b0, 2'b11, 16'hF7F7};
            3'd4:       return {1'b0, 2'b00, r[15:8], r[10:3]};
            3'd5:       return {1'b0, 2'b11, 16'hFEFE};
            3'd6:       return {1'b1, 2'b10, 16'hBCC5};
            default:    return {1'b0, 2'b01, 16'hBCC5};
        endcase
    endfunction

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        do_reset();

        // R10, R7, R8, R9, R11: every single word from acquisition
        for (int hi = 0; hi < 8; hi++)
            for (int lo = 0; lo < 8; lo++)
                for (int k = 0; k < 4; k++)
                    for (int cv = 0; cv < 2; cv++) begin
                        do_reset();
                        apply({pick(hi), pick(lo)}, 2'(k), 1'(cv));
                    end

        // R1..R5, R12: every word in the synchronized state
        do_reset();
        apply(16'hF7F7, 2'b11, 1'b0);
        for (int hi = 0; hi < 8; hi++)
            for (int lo = 0; lo < 8; lo++)
                for (int k = 0; k < 4; k++)
                    for (int cv = 0; cv < 2; cv++)
                        apply({pick(hi), pick(lo)}, 2'(k), 1'(cv));

        // R7 / R11: explicit idle runs
        do_reset();
        apply(16'hBCC5, 2'b10, 1'b0);
        apply(16'hBC50, 2'b10, 1'b0);
        check("R7", "two idles not enough", sync_o, 0);
        apply(16'hBCC5, 2'b10, 1'b0);
        check("R7", "third idle syncs", sync_o, 1);
        do_reset();
        apply(16'hBCC5, 2'b10, 1'b0);
        apply(16'hBCC5, 2'b10, 1'b0);
        apply(16'hBCC5, 2'b10, 1'b1);
        apply(16'hBCC5, 2'b10, 1'b0);
        apply(16'hBCC5, 2'b10, 1'b0);
        check("R11", "interrupted run stays acq", sync_o, 0);
        apply(16'hBC50, 2'b10, 1'b0);
        check("R11", "fresh run of three syncs", sync_o, 1);

        // mixed pseudo-random streams with periodic reset
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            logic [18:0] w;
            if (n % 16 == 0) do_reset();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            w = rand_word(lfsr);
            apply(w[15:0], w[17:16], w[18]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule